// File: doc/BRIEF.md
# Write-Status Polling Read Responder

This block owns the read side of a paged non-volatile memory model. When the memory is idle, a read returns the stored byte for the addressed location. While an internal programming period is running, the same read path returns status instead of array contents. Software can watch either of two status bits to learn when programming ends: the top bit shows the inverted top bit of the byte most recently written, and the bit below it changes value on every new read access.

All inputs are sampled on the rising clock edge. Both outputs are registered, so each reflects the inputs sampled one edge earlier. A read access is the combination of active-low chip select and active-low output enable. A new access begins each time that combination becomes active, so it can be produced by pulsing output enable, chip select, or both. The output-enable result drives an external tristate buffer. Read data is forced to zero whenever that buffer is off.

A three-state controller tracks the programming period. ST_READY is the normal state. It moves to ST_POLL_IDLE on busy when no access is active (transition T_START_IDLE), or to ST_POLL_READ when an access is already active (T_START_READ). ST_POLL_IDLE moves to ST_POLL_READ when an access becomes active (T_ACCESS). ST_POLL_READ returns to ST_POLL_IDLE when the access ends (T_RELEASE). Both poll states return to ST_READY when busy drops (T_DONE). Every entry into ST_POLL_READ counts as one access.

Top module: `poll_rsp_top`

## Requirements
- R1: After reset, `bus_drive` is 0 and `rd_byte` is 0.
- R2: One cycle after sampling `cs_n`=0, `rd_en_n`=0 and `wr_en_n`=1, `bus_drive` is 1. One cycle after any other combination, it is 0.
- R3: Whenever `bus_drive` is 0, `rd_byte` is 0.
- R4: When `busy` is sampled 0 during a driven read, `rd_byte` on the next cycle equals the `mem_byte` sampled with it.
- R5: When `busy` is sampled 1 during a driven read and `rd_addr` equals `wr_addr`, bit 7 of `rd_byte` is the complement of bit 7 of `wr_byte`.
- R6: While busy, bits 5..0 always carry `mem_byte`. Bit 7 also carries `mem_byte` when `rd_addr` differs from `wr_addr`.
- R7: While busy, bit 6 of `rd_byte` is 0 on the first access after busy rises. It inverts on each later access and holds steady for the length of one access.
- R8: A new access is counted when `cs_n` alone, `rd_en_n` alone, or both are raised and lowered again.
- R9: After busy falls, reads return all eight bits of `mem_byte` and bit 6 no longer changes between accesses. The next programming period starts bit 6 at 0 again, whatever the previous period ended with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Programming period in progress |
| wr_addr | input | 17 | Address of the most recently written byte |
| wr_byte | input | 8 | Data of the most recently written byte |
| rd_addr | input | 17 | Address being read |
| mem_byte | input | 8 | Array contents at `rd_addr` |
| cs_n | input | 1 | Chip select, active low |
| rd_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| rd_byte | output | 8 | Read data toward the bus |
| bus_drive | output | 1 | Tristate enable for the data bus |

## Verification
A controller stuck in ST_READY during busy shows up on the first driven poll read, one cycle after the strobes are sampled: bit 7 comes back true instead of inverted. A lost or doubled access count shows up as a wrong bit 6 on the second access. A toggle value that is not cleared at the start of a period appears on the first read of the next programming period. A controller stuck in a poll state after busy falls appears as an inverted bit 7 on the very next driven read.

// File: rtl/poll_rsp_pkg.sv
package poll_rsp_pkg;

    typedef enum logic [1:0] {
        ST_READY     = 2'd0,
        ST_POLL_IDLE = 2'd1,
        ST_POLL_READ = 2'd2
    } poll_state_e;

endpackage

// File: rtl/poll_rsp_strobe.sv
// Decodes the three active-low bus strobes into a read-access level
// and a request to drive the data bus.
module poll_rsp_strobe (
    input  logic cs_n,
    input  logic rd_en_n,
    input  logic wr_en_n,
    output logic rd_act,
    output logic drive_req
);

    always_comb begin
        rd_act    = ~cs_n & ~rd_en_n;
        drive_req = rd_act & wr_en_n;
    end

endmodule

// File: rtl/poll_rsp_fsm.sv
// Tracks the programming period and counts read accesses for the toggle bit.
module poll_rsp_fsm
    import poll_rsp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        busy,
    input  logic        rd_act,
    output poll_state_e state_q,
    output logic        poll_mode_d,
    output logic        tog_shown_d
);

    poll_state_e state_d;
    logic        tog_q;
    logic        tog_d;
    logic        shown_q;
    logic        enter_read;
    logic        tog_base;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (busy) state_d = rd_act ? ST_POLL_READ : ST_POLL_IDLE;
            end
            ST_POLL_IDLE: begin
                if (!busy)       state_d = ST_READY;
                else if (rd_act) state_d = ST_POLL_READ;
            end
            ST_POLL_READ: begin
                if (!busy)        state_d = ST_READY;
                else if (!rd_act) state_d = ST_POLL_IDLE;
            end
            default: state_d = ST_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // toggle bookkeeping: each entry into ST_POLL_READ is one access
    always_comb begin
        enter_read  = (state_d == ST_POLL_READ) && (state_q != ST_POLL_READ);
        tog_base    = (state_q == ST_READY) ? 1'b0 : tog_q;
        tog_d       = enter_read ? ~tog_base : tog_base;
        tog_shown_d = enter_read ? tog_base
                    : ((state_q == ST_READY) ? 1'b0 : shown_q);
        poll_mode_d = (state_d != ST_READY);
    end

    // output-related registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q   <= 1'b0;
            shown_q <= 1'b0;
        end else begin
            tog_q   <= tog_d;
            shown_q <= tog_shown_d;
        end
    end

endmodule

// File: rtl/poll_rsp_out.sv
// Selects array data or status per bit and registers the bus outputs.
module poll_rsp_out #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive_req,
    input  logic              poll_mode,
    input  logic              tog_bit,
    input  logic              addr_hit,
    input  logic              last_msb,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              drive_en
);

    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    logic [DATA_W-1:0] pick;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b == POLL_BIT) begin : g_poll
            assign pick[b] = (poll_mode && addr_hit) ? ~last_msb : array_data[b];
        end else if (b == TOG_BIT) begin : g_tog
            assign pick[b] = poll_mode ? tog_bit : array_data[b];
        end else begin : g_plain
            assign pick[b] = array_data[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            drive_en <= 1'b0;
        end else begin
            drive_en <= drive_req;
            rd_data  <= drive_req ? pick : '0;
        end
    end

endmodule

// File: rtl/poll_rsp_top.sv
module poll_rsp_top
    import poll_rsp_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] mem_byte,
    input  logic              cs_n,
    input  logic              rd_en_n,
    input  logic              wr_en_n,
    output logic [DATA_W-1:0] rd_byte,
    output logic              bus_drive
);

    localparam int POLL_BIT = DATA_W - 1;

    logic        rd_act;
    logic        drive_req;
    poll_state_e state_q;
    logic        poll_mode_d;
    logic        tog_shown_d;
    logic        addr_hit;

    assign addr_hit = (rd_addr == wr_addr);

    poll_rsp_strobe u_strobe (
        .cs_n      (cs_n),
        .rd_en_n   (rd_en_n),
        .wr_en_n   (wr_en_n),
        .rd_act    (rd_act),
        .drive_req (drive_req)
    );

    poll_rsp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (busy),
        .rd_act      (rd_act),
        .state_q     (state_q),
        .poll_mode_d (poll_mode_d),
        .tog_shown_d (tog_shown_d)
    );

    poll_rsp_out #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .drive_req  (drive_req),
        .poll_mode  (poll_mode_d),
        .tog_bit    (tog_shown_d),
        .addr_hit   (addr_hit),
        .last_msb   (wr_byte[POLL_BIT]),
        .array_data (mem_byte),
        .rd_data    (rd_byte),
        .drive_en   (bus_drive)
    );

endmodule

// File: rtl/poll_rsp_chk.sv
module poll_rsp_chk
    import poll_rsp_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_byte,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] mem_byte,
    input logic              cs_n,
    input logic              rd_en_n,
    input logic              wr_en_n,
    input logic [DATA_W-1:0] rd_byte,
    input logic              bus_drive,
    input poll_state_e       state_q
);

    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    assert_drive_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_en_n && wr_en_n) |=> bus_drive);

    assert_drive_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs_n && !rd_en_n && wr_en_n) |=> !bus_drive);

    assert_quiet_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_drive |-> (rd_byte == '0));

    assert_ready_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cs_n && !rd_en_n && wr_en_n) |=> (rd_byte == $past(mem_byte)));

    assert_poll_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cs_n && !rd_en_n && wr_en_n && rd_addr == wr_addr)
        |=> (rd_byte[POLL_BIT] == ~$past(wr_byte[POLL_BIT])));

    assert_tog_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cs_n && !rd_en_n && wr_en_n) ##1 (busy && !cs_n && !rd_en_n && wr_en_n)
        |=> $stable(rd_byte[TOG_BIT]));

    assert_state_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (state_q == ST_READY));

endmodule

bind poll_rsp_top poll_rsp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .wr_addr   (wr_addr),
    .wr_byte   (wr_byte),
    .rd_addr   (rd_addr),
    .mem_byte  (mem_byte),
    .cs_n      (cs_n),
    .rd_en_n   (rd_en_n),
    .wr_en_n   (wr_en_n),
    .rd_byte   (rd_byte),
    .bus_drive (bus_drive),
    .state_q   (state_q)
);

// File: tb/tb_poll_rsp_top.sv
`timescale 1ns/1ps
module tb_poll_rsp_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_byte = '0;
    logic [16:0] rd_addr = '0;
    logic [7:0]  mem_byte = '0;
    logic        cs_n = 1'b1;
    logic        rd_en_n = 1'b1;
    logic        wr_en_n = 1'b1;
    logic [7:0]  rd_byte;
    logic        bus_drive;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    poll_rsp_top dut (
        .clk(clk), .rst_n(rst_n), .busy(busy), .wr_addr(wr_addr), .wr_byte(wr_byte),
        .rd_addr(rd_addr), .mem_byte(mem_byte), .cs_n(cs_n), .rd_en_n(rd_en_n),
        .wr_en_n(wr_en_n), .rd_byte(rd_byte), .bus_drive(bus_drive)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic set_strobes(input logic c, input logic o, input logic w);
        cs_n = c; rd_en_n = o; wr_en_n = w;
    endtask

    task automatic t_reset();
        check("R1 drive after reset", {7'd0, bus_drive}, 8'h00);
        check("R1 data after reset", rd_byte, 8'h00);
    endtask

    task automatic t_strobes();
        mem_byte = 8'hA5;
        set_strobes(0, 1, 1); step();
        check("R2 oe high drive", {7'd0, bus_drive}, 8'h00);
        check("R3 oe high data", rd_byte, 8'h00);
        set_strobes(0, 0, 0); step();
        check("R2 we low drive", {7'd0, bus_drive}, 8'h00);
        check("R3 we low data", rd_byte, 8'h00);
        set_strobes(1, 0, 1); step();
        check("R2 ce high drive", {7'd0, bus_drive}, 8'h00);
        set_strobes(0, 0, 1); step();
        check("R2 read drive", {7'd0, bus_drive}, 8'h01);
    endtask

    task automatic t_ready_read();
        set_strobes(0, 0, 1);
        mem_byte = 8'h5A; step();
        check("R4 ready read 5A", rd_byte, 8'h5A);
        mem_byte = 8'hC3; step();
        check("R4 ready read C3", rd_byte, 8'hC3);
        set_strobes(1, 1, 1); step();
    endtask

    task automatic t_poll();
        wr_addr = 17'h01234; rd_addr = 17'h01234;
        wr_byte = 8'h80; mem_byte = 8'hBF;
        busy = 1'b1; step();
        set_strobes(0, 0, 1); step();
        // first access: bit7 = ~1 = 0, bit6 = 0, low bits from array
        check("R5 R7 first poll", rd_byte, 8'h3F);
        step();
        check("R7 hold within access", rd_byte, 8'h3F);
        set_strobes(0, 1, 1); step();
        check("R3 gap data", rd_byte, 8'h00);
        set_strobes(0, 0, 1); step();
        check("R8 oe-only toggle", rd_byte, 8'h7F);
        mem_byte = 8'h95; step();
        check("R6 low bits track array", rd_byte, 8'h55);
        set_strobes(1, 0, 1); step();
        set_strobes(0, 0, 1); step();
        check("R8 ce-only toggle", rd_byte, 8'h15);
        rd_addr = 17'h01235; step();
        check("R6 other address msb", rd_byte, 8'h95);
        rd_addr = 17'h01234;
        busy = 1'b0; step();
        check("R9 true data after done", rd_byte, 8'h95);
        set_strobes(1, 1, 1); step();
        set_strobes(0, 0, 1); step();
        check("R9 no toggle after done", rd_byte, 8'h95);
        set_strobes(1, 1, 1); step();
    endtask

    task automatic t_restart();
        wr_byte = 8'h00; mem_byte = 8'h00;
        busy = 1'b1; step();
        set_strobes(0, 0, 1); step();
        check("R9 restart toggle zero", rd_byte, 8'h80);
        set_strobes(1, 1, 1); step();
        set_strobes(0, 0, 1); step();
        check("R7 second access toggles", rd_byte, 8'hC0);
        busy = 1'b0; set_strobes(1, 1, 1); step();
    endtask

    initial begin
        #(20 * 100000);
        n_fails++;
        $display("FAIL watchdog run hung actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_strobes();
        t_ready_read();
        t_poll();
        t_restart();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule